// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block supervises software through a 32-bit up-counter. It counts ticks from one of two clock-enable sources, which stand in for a fast oscillator of about 1 MHz and a slow internal oscillator of about 10 kHz, all in one system clock domain. In watchdog mode, the count reaching a selected power of two requests a system reset. In interval mode, the same event instead sets a sticky interrupt flag. In both modes the counter then restarts from zero and keeps running.

Software drives the block through one 16-bit control word. A write takes effect only when its upper byte carries the unlock key. A write with any other upper byte changes nothing and raises a reset request, so stray or corrupted writes are treated as a fault. The block leaves reset already armed in watchdog mode at a short interval of 2^15 ticks. Software must therefore hold it or service it early after start-up.

Top module: `wdt_keyed_timer`

Control word layout: bits [15:8] carry the key on a write (0x5A) and read back as 0x69. The lower byte holds these fields:
- bit 7: hold (1 stops counting).
- bit 6: mode (0 watchdog, 1 interval).
- bit 5: clear strobe.
- bit 4: interrupt flag (write 1 to clear).
- bit 3: source (0 = `src_tick[0]`, 1 = `src_tick[1]`).
- bits [2:0]: tap select.

## Requirements
- R1: After reset, `rd_data` reads 0x6904, and `reset_req` and `irq` are low.
- R2: A write changes the fields only when `wr_data[15:8]` is 0x5A. Reads always return 0x69 in bits [15:8].
- R3: A write whose upper byte is not 0x5A leaves every field unchanged and drives `reset_req` high for exactly the one cycle after the write edge.
- R4: With no writes after reset and `src_tick[0]` high every cycle, `reset_req` first rises after 32768 ticks.
- R5: Tap select values 0..7 choose counter bits 31, 27, 23, 19, 15, 13, 9 and 6. Expiry occurs on the tick that brings the count to 2^bit.
- R6: A keyed write with bit 5 set zeroes the counter on that edge, with priority over a tick. Bit 5 always reads 0.
- R7: While hold (bit 7) is 1, the counter does not advance and no expiry occurs.
- R8: Source bit 3 selects which `src_tick` bit advances the counter. Ticks on the other bit have no effect.
- R9: In interval mode, expiry sets `irq` (bit 4) without raising `reset_req`. The counter restarts from zero and keeps counting, and `irq` stays set until it is cleared.
- R10: A keyed write with bit 4 set clears the interrupt flag. An expiry in the same cycle wins.
- R11: In watchdog mode, each expiry gives a one-cycle `reset_req` pulse and restarts the count from zero. The interrupt flag is never set in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick | input | 2 | Clock-enable pulses of the two tick sources |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Write data, key in the upper byte |
| rd_data | output | 16 | Control word read value |
| reset_req | output | 1 | System reset request pulse |
| irq | output | 1 | Interval interrupt flag |

## Verification
The bench measures the exact tick count to expiry for several taps and for the power-on default. A design that compares against the wrong bit, or that fires one tick early or late, shows up as a count that is off by a power of two or by one. A clear issued partway through a period must give a full period afterwards; a design that ignores the strobe expires early. Hold and the unselected source must produce no expiry over a long window. A wrong-key write must produce a single reset pulse while the fields stay intact; a design that applies the write or stretches the pulse is caught by that check. In interval mode the bench checks that no reset is requested and that the flag is sticky. It also checks that the counter kept running during the flag clear, because a design that stops or restarts it on the clear expires at the wrong time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [7:0] KEY_WRITE = 8'h5A;
  localparam logic [7:0] KEY_READ  = 8'h69;

  localparam int F_HOLD = 7;
  localparam int F_MODE = 6;
  localparam int F_CLR  = 5;
  localparam int F_FLAG = 4;
  localparam int F_SRC  = 3;
  localparam int TAP_W  = 3;
  localparam int NUM_TAPS = 1 << TAP_W;

  typedef enum logic {
    MODE_WDOG = 1'b0,
    MODE_INTV = 1'b1
  } wdt_mode_e;

  typedef struct packed {
    logic             hold;
    wdt_mode_e        mode;
    logic             src;
    logic [TAP_W-1:0] tap;
  } wdt_cfg_t;

  localparam wdt_cfg_t CFG_RESET = '{hold: 1'b0, mode: MODE_WDOG, src: 1'b0, tap: 3'd4};

  function automatic int tap_bit(input int sel);
    case (sel)
      0:       tap_bit = 31;
      1:       tap_bit = 27;
      2:       tap_bit = 23;
      3:       tap_bit = 19;
      4:       tap_bit = 15;
      5:       tap_bit = 13;
      6:       tap_bit = 9;
      default: tap_bit = 6;
    endcase
  endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int KEY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output wdt_cfg_t          cfg_o,
  output logic              clr_o,
  output logic              flag_clr_o,
  output logic              key_bad_o
);

  wdt_cfg_t cfg_q, cfg_d;
  logic     key_ok;
  logic     wr_good;

  always_comb begin
    key_ok  = (wr_data[DATA_W-1 -: KEY_W] == KEY_WRITE);
    wr_good = wr_en && key_ok;
    cfg_d   = cfg_q;
    if (wr_good) begin
      cfg_d.hold = wr_data[F_HOLD];
      cfg_d.mode = wdt_mode_e'(wr_data[F_MODE]);
      cfg_d.src  = wr_data[F_SRC];
      cfg_d.tap  = wr_data[TAP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign clr_o      = wr_good && wr_data[F_CLR];
  assign flag_clr_o = wr_good && wr_data[F_FLAG];
  assign key_bad_o  = wr_en && !key_ok;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] lim_mask [NUM_TAPS];
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             hit;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int BIT = (tap_bit(g) < CNT_W) ? tap_bit(g) : CNT_W - 1;
    assign lim_mask[g] = {CNT_W{1'b1}} << BIT;
  end

  always_comb begin
    cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    hit     = tick_i && !clr_i && (|(cnt_inc & lim_mask[tap_i]));
    if (clr_i || hit) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_inc;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign hit_o = hit;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/wdt_event.sv
module wdt_event
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit_i,
  input  wdt_mode_e mode_i,
  input  logic      key_bad_i,
  input  logic      flag_clr_i,
  output logic      reset_req_o,
  output logic      flag_o
);

  logic req_q, req_d;
  logic flag_q, flag_d;

  always_comb begin
    req_d = key_bad_i || (hit_i && (mode_i == MODE_WDOG));
    if (hit_i && (mode_i == MODE_INTV)) begin
      flag_d = 1'b1;
    end else if (flag_clr_i) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      flag_q <= flag_d;
    end
  end

  assign reset_req_o = req_q;
  assign flag_o      = flag_q;

endmodule

// File: rtl/wdt_keyed_timer.sv
module wdt_keyed_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 16,
  parameter int KEY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              reset_req,
  output logic              irq
);

  localparam int LOW_W = DATA_W - KEY_W;

  logic             rst_meta, rst_n_s;
  wdt_cfg_t         cfg;
  logic             clr_pulse, flag_clr, key_bad;
  logic             tick_sel, tick_run;
  logic             hit;
  logic [CNT_W-1:0] cnt_w;
  logic             flag;
  logic [LOW_W-1:0] rd_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  wdt_ctrl_reg #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .cfg_o      (cfg),
    .clr_o      (clr_pulse),
    .flag_clr_o (flag_clr),
    .key_bad_o  (key_bad)
  );

  always_comb begin
    tick_sel = cfg.src ? src_tick[1] : src_tick[0];
    tick_run = tick_sel && !cfg.hold;
  end

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .tick_i (tick_run),
    .clr_i  (clr_pulse),
    .tap_i  (cfg.tap),
    .hit_o  (hit),
    .cnt_o  (cnt_w)
  );

  wdt_event u_evt (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .hit_i       (hit),
    .mode_i      (cfg.mode),
    .key_bad_i   (key_bad),
    .flag_clr_i  (flag_clr),
    .reset_req_o (reset_req),
    .flag_o      (flag)
  );

  always_comb begin
    rd_low            = '0;
    rd_low[F_HOLD]    = cfg.hold;
    rd_low[F_MODE]    = cfg.mode;
    rd_low[F_CLR]     = 1'b0;
    rd_low[F_FLAG]    = flag;
    rd_low[F_SRC]     = cfg.src;
    rd_low[TAP_W-1:0] = cfg.tap;
  end

  assign rd_data = {KEY_READ, rd_low};
  assign irq     = flag;

endmodule

// File: rtl/wdt_keyed_timer_chk.sv
module wdt_keyed_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_key,
  input logic             wr_clr,
  input logic [6:0]       rd_ctl,
  input logic             reset_req,
  input logic             irq,
  input logic [CNT_W-1:0] cnt
);

  logic hold_r, mode_r;
  assign hold_r = rd_ctl[6];
  assign mode_r = rd_ctl[5];

  AST_BAD_KEY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_key != 8'h5A) |=> reset_req); // R3
  AST_BAD_KEY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_key != 8'h5A) |=> (rd_ctl == $past(rd_ctl))); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_key == 8'h5A && wr_clr) |=> (cnt == '0)); // R6
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_r && !wr_en) |=> (cnt == $past(cnt))); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_en) |=> irq); // R9
  AST_WDOG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !mode_r) |=> !irq); // R11

endmodule

bind wdt_keyed_timer wdt_keyed_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .wr_en     (wr_en),
  .wr_key    (wr_data[15:8]),
  .wr_clr    (wr_data[5]),
  .rd_ctl    ({rd_data[7:5], rd_data[3:0]}),
  .reset_req (reset_req),
  .irq       (irq),
  .cnt       (cnt_w)
);

// File: tb/wdt_keyed_timer_test.sv
module wdt_keyed_timer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  src_tick;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        reset_req;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  int req_cnt = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  wdt_keyed_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_tick  (src_tick),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .reset_req (reset_req),
    .irq       (irq)
  );

  always @(negedge clk) begin
    cyc++;
    if (reset_req === 1'b1) req_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; src_tick = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_evt(input bit use_irq, input int lim, output int n, output bit seen);
    n = 0; seen = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      n++;
      if ((use_irq ? irq : reset_req) === 1'b1) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset rd_data", rd_data, 32'h6904);
    chk("R1 reset reset_req", reset_req, 0);
    chk("R1 reset irq", irq, 0);
  endtask

  task automatic t_default();
    int n; bit s;
    do_reset();
    src_tick = 2'b01;
    wait_evt(1'b0, 40000, n, s);
    chk("R4 default interval ticks", n, 32768);
  endtask

  task automatic t_key();
    do_reset();
    wr(16'h5A47);
    chk("R2 keyed write applied", rd_data, 32'h6947);
    wr(16'h69C0);
    chk("R2 read key not accepted as write key", rd_data, 32'h6947);
  endtask

  task automatic t_badkey();
    do_reset();
    wr(16'h5A07);
    wr(16'hA5C3);
    chk("R3 bad key raises reset_req", reset_req, 1);
    chk("R3 bad key fields unchanged", rd_data, 32'h6907);
    @(negedge clk);
    chk("R3 reset_req lasts one cycle", reset_req, 0);
  endtask

  task automatic t_tap(input logic [2:0] tap, input int exp);
    int n; bit s;
    do_reset();
    src_tick = 2'b01;
    wr({8'h5A, 5'b00100, tap});
    wait_evt(1'b0, exp + 10, n, s);
    chk($sformatf("R5 tap %0d expiry ticks", tap), n, exp);
  endtask

  task automatic t_wdog_repeat();
    int n; bit s;
    do_reset();
    src_tick = 2'b01;
    wr(16'h5A27);
    wait_evt(1'b0, 100, n, s);
    chk("R11 first expiry", n, 64);
    @(negedge clk);
    chk("R11 pulse is one cycle", reset_req, 0);
    wait_evt(1'b0, 100, n, s);
    chk("R11 restart gives full period", n, 63);
    chk("R11 no flag in watchdog mode", irq, 0);
  endtask

  task automatic t_clear();
    int n; bit s;
    do_reset();
    src_tick = 2'b01;
    wr(16'h5A27);
    repeat (40) @(negedge clk);
    wr(16'h5A27);
    chk("R6 clear bit reads zero", rd_data, 32'h6907);
    wait_evt(1'b0, 100, n, s);
    chk("R6 full period after clear", n, 64);
  endtask

  task automatic t_hold();
    int n; bit s;
    do_reset();
    src_tick = 2'b01;
    wr(16'h5AA7);
    chk("R7 hold readback", rd_data, 32'h6987);
    wait_evt(1'b0, 200, n, s);
    chk("R7 no expiry while held", s, 0);
    wr(16'h5A07);
    wait_evt(1'b0, 100, n, s);
    chk("R7 count resumes from zero", n, 64);
  endtask

  task automatic t_src();
    int n; bit s;
    do_reset();
    src_tick = 2'b01;
    wr(16'h5A2F);
    chk("R8 source readback", rd_data, 32'h690F);
    wait_evt(1'b0, 200, n, s);
    chk("R8 unselected source ignored", s, 0);
    src_tick = 2'b10;
    wait_evt(1'b0, 100, n, s);
    chk("R8 selected source counts", n, 64);
  endtask

  task automatic t_interval();
    int n; bit s; int r0;
    do_reset();
    src_tick = 2'b01;
    r0 = req_cnt;
    wr(16'h5A67);
    wait_evt(1'b1, 100, n, s);
    chk("R9 interval expiry ticks", n, 64);
    chk("R9 flag readback", rd_data, 32'h6957);
    repeat (10) @(negedge clk);
    chk("R9 flag sticky", irq, 1);
    wr(16'h5A57);
    chk("R10 write one clears flag", irq, 0);
    wait_evt(1'b1, 100, n, s);
    chk("R9 counter kept running", n, 53);
    chk("R9 no reset request in interval mode", req_cnt - r0, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_key();
        t_badkey();
        t_tap(3'd7, 64);
        t_tap(3'd6, 512);
        t_tap(3'd5, 8192);
        t_wdog_repeat();
        t_clear();
        t_hold();
        t_src();
        t_interval();
        t_default();
      end
      begin
        wait (cyc > 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule